// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block is the coherence engine of one write-back, write-allocate cache on a shared snooping bus. It holds a small direct-mapped array of lines. Each line has a tag, one data word and one of three coherence states: Invalid (no copy), Shared (a clean copy that memory and possibly other caches also hold) or Modified (the only copy, and it is dirty). A processor access looks up the array. It either completes locally or places a single command on the bus: a shared read, a read with intent to own, or a write-back of a dirty victim. It then waits for the fill word.

Traffic from other caches arrives on a separate snoop input. A shared read that hits a Modified line makes the controller drive that line's data on the flush output and drop the line to Shared. A read with intent to own invalidates the line, and it flushes first if the line was dirty. Memory is assumed to capture any flushed word, so after a flush the line is clean in memory. Bus arbitration is outside this block: a command is presented for exactly one cycle and is taken to be accepted.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_cmd` is 00, `cpu_ready` is 1, and `cpu_done` and `flush_valid` are 0.
- R2: A read to a line that is not present issues one bus command 01 (shared read) carrying the request address. It returns the fill word on `cpu_rdata` and leaves the line Shared.
- R3: A write to a line that is Invalid, or present in Shared, issues one bus command 10 (read for ownership) carrying the request address. It leaves the line Modified and holding the write data, whatever the fill word is.
- R4: A read hit in Shared or Modified, and a write hit in Modified, put no command on the bus. `cpu_done` rises in the second cycle after the request is accepted, and `cpu_rdata` gives the line's current word.
- R5: A snooped shared read (`snp_cmd` 01) that hits a Modified line raises `flush_valid` for one cycle, in the cycle after the snoop, with the line's data, and the line becomes Shared.
- R6: A snooped read for ownership (`snp_cmd` 10) that hits a Modified line flushes as in R5 and makes the line Invalid. One that hits a Shared line makes it Invalid with no flush.
- R7: A snooped shared read to a Shared or Invalid line, any snoop whose tag differs from the stored tag, and a snooped write-back (`snp_cmd` 11) cause no flush and leave the line unchanged.
- R8: A miss whose indexed line is Modified with another tag first issues command 11 (write-back) with the victim's address and data. The new request's command follows in the very next cycle. A Shared victim is dropped with no write-back.
- R9: Commands 01, 10 and 11 each last one cycle. `cpu_ready` is 0 from the cycle after acceptance until the access ends. `cpu_done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, sampled while `cpu_ready` is high |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Access address; low bits index the array, upper bits are the tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle pulse ending an access |
| cpu_rdata | output | DATA_W | Word returned with `cpu_done` |
| bus_cmd | output | 2 | Issued command: 00 idle, 01 shared read, 10 read for ownership, 11 write-back |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Victim data for a write-back command |
| fill_valid | input | 1 | Fill word valid for the outstanding read |
| fill_data | input | DATA_W | Fill word |
| snp_cmd | input | 2 | Snooped command from another cache, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Flush of a dirty line onto the bus |
| flush_data | output | DATA_W | Flushed word |

## Verification
A line whose state has gone wrong becomes visible at the ports at the next access to it. A line wrongly left Modified flushes on a snooped shared read one cycle later, or writes back on an eviction. A line wrongly in Shared or Invalid issues a bus command where a silent hit was due, or stays silent where a flush was due. The bench therefore probes each line's state by following every transition with a snoop or a processor access whose visible reaction differs by state. It also checks word values end to end, so that a wrong flush or victim payload shows up.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LINE_I = 2'd0,
      LINE_S = 2'd1,
      LINE_M = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'b00,
      CMD_RD   = 2'b01,
      CMD_RDX  = 2'b10,
      CMD_WB   = 2'b11
   } bus_cmd_e;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
   import msi_pkg::*;
#(
   parameter int NUM_LINES     = 4,
   parameter int TAG_W         = 6,
   parameter int DATA_W        = 16,
   parameter bit CLEAR_PAYLOAD = 1'b1,
   localparam int IDX_W        = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  c_idx,
   input  logic              c_we,
   input  line_st_e          c_st,
   input  logic [TAG_W-1:0]  c_tag,
   input  logic [DATA_W-1:0] c_data,
   output line_st_e          c_rd_st,
   output logic [TAG_W-1:0]  c_rd_tag,
   output logic [DATA_W-1:0] c_rd_data,
   input  logic [IDX_W-1:0]  s_idx,
   input  logic              s_we,
   input  line_st_e          s_st,
   output line_st_e          s_rd_st,
   output logic [TAG_W-1:0]  s_rd_tag,
   output logic [DATA_W-1:0] s_rd_data
);
   line_st_e          st_all   [NUM_LINES];
   logic [TAG_W-1:0]  tag_all  [NUM_LINES];
   logic [DATA_W-1:0] data_all [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              c_hit_w;
      logic              s_hit_w;

      assign c_hit_w = c_we && (c_idx == IDX_W'(i));
      assign s_hit_w = s_we && (s_idx == IDX_W'(i));

      // processor-side install wins over a snoop update in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       st_q <= LINE_I;
         else if (c_hit_w) st_q <= c_st;
         else if (s_hit_w) st_q <= s_st;
      end

      if (CLEAR_PAYLOAD) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q  <= '0;
               data_q <= '0;
            end else if (c_hit_w) begin
               tag_q  <= c_tag;
               data_q <= c_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (c_hit_w) begin
               tag_q  <= c_tag;
               data_q <= c_data;
            end
         end
      end

      assign st_all[i]   = st_q;
      assign tag_all[i]  = tag_q;
      assign data_all[i] = data_q;
   end

   assign c_rd_st   = st_all[c_idx];
   assign c_rd_tag  = tag_all[c_idx];
   assign c_rd_data = data_all[c_idx];
   assign s_rd_st   = st_all[s_idx];
   assign s_rd_tag  = tag_all[s_idx];
   assign s_rd_data = data_all[s_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
   import msi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_cmd_e          snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_e          rd_st,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic [DATA_W-1:0] rd_data,
   output logic              s_we,
   output line_st_e          s_st,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data
);
   logic present_w;
   logic flush_w;

   assign present_w = (rd_st != LINE_I) && (rd_tag == snp_tag);

   always_comb begin
      s_we    = 1'b0;
      s_st    = rd_st;
      flush_w = 1'b0;
      unique case (snp_cmd)
         CMD_RD: if (present_w && rd_st == LINE_M) begin
            s_we    = 1'b1;
            s_st    = LINE_S;
            flush_w = 1'b1;
         end
         CMD_RDX: if (present_w) begin
            s_we    = 1'b1;
            s_st    = LINE_I;
            flush_w = (rd_st == LINE_M);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_valid <= 1'b0;
         flush_data  <= '0;
      end else begin
         flush_valid <= flush_w;
         if (flush_w) flush_data <= rd_data;
      end
   end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
   import msi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output bus_cmd_e          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [IDX_W-1:0]  a_idx,
   input  line_st_e          a_st,
   input  logic [TAG_W-1:0]  a_tag,
   input  logic [DATA_W-1:0] a_data,
   output logic              a_we,
   output line_st_e          a_wst,
   output logic [TAG_W-1:0]  a_wtag,
   output logic [DATA_W-1:0] a_wdata
);
   typedef enum logic [2:0] {F_IDLE, F_LOOK, F_WB, F_REQ, F_WAIT, F_DONE} fsm_e;

   fsm_e              st_q, st_d;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d, vic_data_q;
   logic [TAG_W-1:0]  tag_q, vic_tag_q;
   logic              present_w, fill_w, vic_load;

   assign tag_q     = addr_q[ADDR_W-1:IDX_W];
   assign a_idx     = addr_q[IDX_W-1:0];
   assign present_w = (a_st != LINE_I) && (a_tag == tag_q);
   assign fill_w    = fill_valid && (st_q == F_REQ || st_q == F_WAIT);

   always_comb begin
      st_d     = st_q;
      a_we     = 1'b0;
      a_wst    = a_st;
      a_wtag   = a_tag;
      a_wdata  = a_data;
      rdata_d  = rdata_q;
      vic_load = 1'b0;
      unique case (st_q)
         F_IDLE: if (cpu_req) st_d = F_LOOK;
         F_LOOK: begin
            if (present_w && (!we_q || a_st == LINE_M)) begin
               a_we    = we_q;
               a_wst   = LINE_M;
               a_wdata = wdata_q;
               rdata_d = we_q ? wdata_q : a_data;
               st_d    = F_DONE;
            end else if (!present_w && a_st == LINE_M) begin
               // dirty victim: drop it locally, its data leaves with the write-back
               a_we     = 1'b1;
               a_wst    = LINE_I;
               vic_load = 1'b1;
               st_d     = F_WB;
            end else begin
               st_d = F_REQ;
            end
         end
         F_WB:    st_d = F_REQ;
         F_REQ, F_WAIT: begin
            if (fill_w) begin
               a_we    = 1'b1;
               a_wst   = we_q ? LINE_M : LINE_S;
               a_wtag  = tag_q;
               a_wdata = we_q ? wdata_q : fill_data;
               rdata_d = a_wdata;
               st_d    = F_DONE;
            end else begin
               st_d = F_WAIT;
            end
         end
         F_DONE:  st_d = F_IDLE;
         default: st_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= F_IDLE;
         we_q       <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         vic_tag_q  <= '0;
         vic_data_q <= '0;
      end else begin
         st_q    <= st_d;
         rdata_q <= rdata_d;
         if (st_q == F_IDLE && cpu_req) begin
            we_q    <= cpu_we;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
         end
         if (vic_load) begin
            vic_tag_q  <= a_tag;
            vic_data_q <= a_data;
         end
      end
   end

   always_comb begin
      bus_cmd  = CMD_IDLE;
      bus_addr = addr_q;
      if (st_q == F_WB) begin
         bus_cmd  = CMD_WB;
         bus_addr = {vic_tag_q, a_idx};
      end else if (st_q == F_REQ) begin
         bus_cmd = we_q ? CMD_RDX : CMD_RD;
      end
   end

   assign bus_wdata = vic_data_q;
   assign cpu_ready = (st_q == F_IDLE);
   assign cpu_done  = (st_q == F_DONE);
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int NUM_LINES     = 4,
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter bit CLEAR_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data
);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  a_idx;
   line_st_e          a_st, a_wst, s_st_rd, s_wst;
   logic [TAG_W-1:0]  a_tag, a_wtag, s_tag_rd;
   logic [DATA_W-1:0] a_data, a_wdata, s_data_rd;
   logic              a_we, s_we;
   bus_cmd_e          cmd_w;

   msi_line_array #(
      .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
   ) i_array (
      .clk(clk), .rst_n(rst_n),
      .c_idx(a_idx), .c_we(a_we), .c_st(a_wst), .c_tag(a_wtag), .c_data(a_wdata),
      .c_rd_st(a_st), .c_rd_tag(a_tag), .c_rd_data(a_data),
      .s_idx(snp_addr[IDX_W-1:0]), .s_we(s_we), .s_st(s_wst),
      .s_rd_st(s_st_rd), .s_rd_tag(s_tag_rd), .s_rd_data(s_data_rd)
   );

   msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
      .rd_st(s_st_rd), .rd_tag(s_tag_rd), .rd_data(s_data_rd),
      .s_we(s_we), .s_st(s_wst),
      .flush_valid(flush_valid), .flush_data(flush_data)
   );

   msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .bus_cmd(cmd_w), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
      .a_we(a_we), .a_wst(a_wst), .a_wtag(a_wtag), .a_wdata(a_wdata)
   );

   assign bus_cmd = cmd_w;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_ready,
   input logic       cpu_done,
   input logic [1:0] bus_cmd,
   input logic [1:0] snp_cmd,
   input logic       flush_valid
);
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bus_cmd == 2'b00 && !flush_valid && !cpu_done && cpu_ready));

   p_flush_from_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> ($past(snp_cmd) == 2'b01 || $past(snp_cmd) == 2'b10));

   p_no_flush_on_wb_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_cmd == 2'b11 || snp_cmd == 2'b00) |=> !flush_valid);

   p_wb_then_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'b11) |=> (bus_cmd == 2'b01 || bus_cmd == 2'b10));

   p_request_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == 2'b01 || bus_cmd == 2'b10) |=> (bus_cmd == 2'b00));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   p_busy_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_ready);

   p_no_cmd_when_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> (bus_cmd == 2'b00));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
   .bus_cmd(bus_cmd), .snp_cmd(snp_cmd), .flush_valid(flush_valid)
);

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_done;
   logic [15:0] cpu_rdata;
   logic [1:0]  bus_cmd;
   logic [7:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic        fill_valid = 1'b0;
   logic [15:0] fill_data = '0;
   logic [1:0]  snp_cmd = 2'b00;
   logic [7:0]  snp_addr = '0;
   logic        flush_valid;
   logic [15:0] flush_data;

   int errors = 0;
   int checks = 0;

   // results of the last access
   int          n_cmd, n_done;
   logic [1:0]  cmds [4];
   logic [7:0]  addrs [4];
   logic [15:0] wbd [4];
   logic [15:0] got_rdata;
   logic        busy_ok;
   // results of the last snoop
   logic        got_fv;
   logic [15:0] got_fd;

   always #2 clk = ~clk;

   msi_snoop_ctrl i_msi_snoop_ctrl (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [7:0] a, input logic [15:0] wd,
                         input logic [15:0] fd);
      logic seen;
      seen   = 1'b0;
      n_cmd  = 0;
      n_done = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      busy_ok = !cpu_ready;
      for (int k = 0; k < 20; k++) begin
         if (bus_cmd != 2'b00) begin
            if (n_cmd < 4) begin
               cmds[n_cmd] = bus_cmd; addrs[n_cmd] = bus_addr; wbd[n_cmd] = bus_wdata;
            end
            n_cmd++;
            if (bus_cmd == 2'b01 || bus_cmd == 2'b10) begin
               fill_valid = 1'b1; fill_data = fd;
            end
         end
         if (cpu_done) begin
            n_done++;
            got_rdata = cpu_rdata;
         end
         if (seen) break;
         seen = cpu_done;
         @(negedge clk);
         fill_valid = 1'b0;
      end
   endtask

   task automatic snoop(input logic [1:0] c, input logic [7:0] a);
      @(negedge clk);
      snp_cmd = c; snp_addr = a;
      @(negedge clk);
      snp_cmd = 2'b00;
      got_fv = flush_valid;
      got_fd = flush_data;
   endtask

   task automatic t_reset;
      check("R1 bus_cmd idle", 32'(bus_cmd), 0);
      check("R1 cpu_ready", 32'(cpu_ready), 1);
      check("R1 flush_valid", 32'(flush_valid), 0);
      check("R1 cpu_done", 32'(cpu_done), 0);
   endtask

   task automatic t_read_miss;
      access(1'b0, 8'h15, 16'h0, 16'hA5A5);
      check("R2 one command", 32'(n_cmd), 1);
      check("R2 shared read code", 32'(cmds[0]), 32'h1);
      check("R2 address", 32'(addrs[0]), 32'h15);
      check("R2 fill returned", 32'(got_rdata), 32'hA5A5);
      check("R9 busy during access", 32'(busy_ok), 1);
      check("R9 single done", 32'(n_done), 1);
      access(1'b0, 8'h15, 16'h0, 16'h0);
      check("R4 shared read hit silent", 32'(n_cmd), 0);
      check("R4 shared hit data", 32'(got_rdata), 32'hA5A5);
      snoop(2'b01, 8'h15);
      check("R7 shared read on Shared no flush", 32'(got_fv), 0);
   endtask

   task automatic t_write_miss;
      access(1'b1, 8'h22, 16'h1234, 16'hFFFF);
      check("R3 one command", 32'(n_cmd), 1);
      check("R3 ownership code", 32'(cmds[0]), 32'h2);
      check("R3 address", 32'(addrs[0]), 32'h22);
      access(1'b1, 8'h22, 16'h5678, 16'h0);
      check("R4 write hit Modified silent", 32'(n_cmd), 0);
      access(1'b0, 8'h22, 16'h0, 16'h0);
      check("R4 read hit Modified silent", 32'(n_cmd), 0);
      check("R4 read hit Modified data", 32'(got_rdata), 32'h5678);
      snoop(2'b01, 8'h22);
      check("R5 flush raised", 32'(got_fv), 1);
      check("R5 flush data", 32'(got_fd), 32'h5678);
      snoop(2'b01, 8'h22);
      check("R5 downgraded so no second flush", 32'(got_fv), 0);
      access(1'b0, 8'h22, 16'h0, 16'h0);
      check("R5 still present as Shared", 32'(n_cmd), 0);
      access(1'b1, 8'h22, 16'h9999, 16'h5678);
      check("R3 upgrade from Shared", 32'(n_cmd), 1);
      check("R3 upgrade code", 32'(cmds[0]), 32'h2);
   endtask

   task automatic t_snoop_own;
      snoop(2'b10, 8'h22);
      check("R6 flush on Modified", 32'(got_fv), 1);
      check("R6 flush data", 32'(got_fd), 32'h9999);
      snoop(2'b10, 8'h22);
      check("R6 invalid afterwards no flush", 32'(got_fv), 0);
      access(1'b0, 8'h22, 16'h0, 16'h3333);
      check("R6 line invalid so read misses", 32'(n_cmd), 1);
      check("R6 miss code", 32'(cmds[0]), 32'h1);
      snoop(2'b10, 8'h22);
      check("R6 Shared invalidated without flush", 32'(got_fv), 0);
      access(1'b0, 8'h22, 16'h0, 16'h4444);
      check("R6 Shared gone so read misses", 32'(n_cmd), 1);
   endtask

   task automatic t_snoop_ignore;
      access(1'b1, 8'h15, 16'h4444, 16'h0);
      check("R3 write on Shared line", 32'(cmds[0]), 32'h2);
      snoop(2'b01, 8'h55);
      check("R7 tag mismatch no flush", 32'(got_fv), 0);
      snoop(2'b11, 8'h15);
      check("R7 write-back snoop no flush", 32'(got_fv), 0);
      snoop(2'b01, 8'h15);
      check("R7 line kept Modified", 32'(got_fv), 1);
      check("R7 line kept data", 32'(got_fd), 32'h4444);
   endtask

   task automatic t_evict;
      access(1'b1, 8'h15, 16'h7777, 16'h0);
      access(1'b0, 8'h35, 16'h0, 16'h0BBB);
      check("R8 two commands", 32'(n_cmd), 2);
      check("R8 write-back first", 32'(cmds[0]), 32'h3);
      check("R8 victim address", 32'(addrs[0]), 32'h15);
      check("R8 victim data", 32'(wbd[0]), 32'h7777);
      check("R8 then shared read", 32'(cmds[1]), 32'h1);
      check("R8 new address", 32'(addrs[1]), 32'h35);
      check("R8 new data", 32'(got_rdata), 32'h0BBB);
      access(1'b0, 8'h15, 16'h0, 16'h1111);
      check("R8 Shared victim dropped silently", 32'(n_cmd), 1);
      check("R8 only a shared read", 32'(cmds[0]), 32'h1);
      check("R9 single done on miss", 32'(n_done), 1);
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_read_miss;
      t_write_miss;
      t_snoop_own;
      t_snoop_ignore;
      t_evict;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule